// File: doc/BRIEF.md
# I2C Register Target with SCL-Low Watchdog

This block is the bus-facing front end of a register-mapped peripheral. It watches the two I2C lines through a two-flop synchroniser and recognises START and STOP conditions. It compares the first byte of a transfer against a fixed 7-bit device address and acknowledges a match. It then moves data between the bus and a simple internal register port. In a write transfer, the first byte after the address sets an internal pointer. Every later byte is written to the register the pointer selects, and the pointer then advances. A read streams bytes out starting at the pointer and advances it after each byte fetched, until the host answers with a NACK.

A watchdog counts system-clock cycles while the synchronised SCL stays low and clears whenever SCL is high. When the count reaches `TIMEOUT_CYC`, the protocol engine drops back to idle and releases SDA. A byte that was still arriving is thrown away. This lets a host that lost track of a transfer, for example after its own reset, recover: it clocks SCL until SDA is high and then issues a START. The limit also sets the slowest SCL low phase that the bus may use.

The engine states are ST_IDLE, ST_ADDR (address shifting), ST_ADDR_ACK, ST_WR_BYTE, ST_WR_ACK, ST_RD_BYTE and ST_RD_ACK (the host's acknowledge slot). The transitions are:
- ST_IDLE to ST_ADDR on START. START also leads to ST_ADDR from every other state.
- ST_ADDR to ST_ADDR_ACK on an address match at the SCL fall that ends the eighth bit. On a mismatch, ST_ADDR returns to ST_IDLE.
- ST_ADDR_ACK to ST_WR_BYTE or ST_RD_BYTE, by the R/W bit.
- ST_WR_BYTE to ST_WR_ACK, and ST_WR_ACK back to ST_WR_BYTE.
- ST_RD_BYTE to ST_RD_ACK. From ST_RD_ACK the engine goes back to ST_RD_BYTE on a host ACK, or to ST_IDLE on a NACK.
- STOP or a watchdog expiry leads to ST_IDLE from any state.

Top module: `i2c_timeout_target`

## Requirements
- R1: A START (SDA falling while SCL is high) in any state clears the bit count, releases SDA and begins address reception. A STOP (SDA rising while SCL is high) returns the engine to idle.
- R2: The address byte is seven address bits, MSB first, followed by the R/W bit (1 = read). On a match with DEV_ADDR the target pulls SDA low for the ninth clock. On a mismatch it gives no acknowledge and ignores the bus until the next START. The SDA drive changes only while SCL is low.
- R3: In a write, the first data byte loads the pointer from its low ADDR_W bits. Each later byte is acknowledged and written to the register at the pointer, and the pointer then increments, wrapping modulo 2^ADDR_W.
- R4: A read returns register contents MSB first, starting at the pointer, and increments the pointer after each byte fetched. A read addressed without a pointer byte continues from where the previous transfer left the pointer.
- R5: When the host answers a read byte with a NACK (SDA high in the ninth clock), the target releases SDA and drives nothing more until the next START. No further byte is fetched.
- R6: When SCL has been low for TIMEOUT_CYC consecutive system clocks, the engine returns to idle and releases SDA, even in the middle of driving a read bit. The count restarts whenever SCL is high.
- R7: A data byte that is incomplete when the watchdog expires is never written to any register.
- R8: After a watchdog expiry the target acknowledges nothing until a new START. After that START it works normally.
- R9: SCL low phases of TIMEOUT_CYC-1 cycles or fewer leave a transfer undisturbed.
- R10: The write strobe is a single-cycle pulse, one per completed data byte and none for the pointer byte. It is asserted in the cycle after the synchronised SCL fall that ends the eighth bit.
- R11: During and after reset, SDA is released and both register strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all logic runs on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 = pull SDA low (open-drain enable) |
| reg_wr_en | output | 1 | Single-cycle register write strobe |
| reg_wr_addr | output | ADDR_W | Register index for the write |
| reg_wr_data | output | 8 | Byte to be written |
| reg_rd_en | output | 1 | Single-cycle strobe when a read byte is fetched |
| reg_rd_addr | output | ADDR_W | Register index to read (current pointer) |
| reg_rd_data | input | 8 | Combinational read data for reg_rd_addr |

## Verification
The bench builds the target with ADDR_W = 4, TIMEOUT_CYC = 40 and device address 0x2C. The 16-entry register space lets a burst started at every one of the 16 pointer values be written and read back, so every wrap point is crossed. Every one of the 127 foreign addresses is also tried. The short limit puts the watchdog boundary within reach of single bit periods: a 39-cycle low phase must pass and a 40-cycle one must abort. This covers both an aborted write byte and a read aborted while the target drives SDA low.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_BYTE,
        ST_WR_ACK,
        ST_RD_BYTE,
        ST_RD_ACK
    } tgt_state_t;

    localparam int BYTE_BITS = 8;
    localparam int BIT_CNT_W = 4;

endpackage

// File: rtl/i2c_line_sync.sv
// Synchroniser for one bus line plus one extra stage for edge detection.
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic level_o,
    output logic rise_o,
    output logic fall_o
);
    logic [STAGES:0] pipe_q;

    // Idle bus level is high, so the pipe resets to ones.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '1;
        else        pipe_q <= {pipe_q[STAGES-1:0], line_i};
    end

    assign level_o = pipe_q[STAGES-1];
    assign rise_o  = pipe_q[STAGES-1] & ~pipe_q[STAGES];
    assign fall_o  = ~pipe_q[STAGES-1] & pipe_q[STAGES];
endmodule

// File: rtl/i2c_low_watchdog.sv
// Counts consecutive cycles with SCL low; fires once when the limit is reached.
module i2c_low_watchdog #(
    parameter int LIMIT = 100000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_lvl_i,
    output logic fire_o
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    cnt_q <= '0;
        else if (scl_lvl_i)            cnt_q <= '0;
        else if (cnt_q != CW'(LIMIT))  cnt_q <= cnt_q + CW'(1);
    end

    // Fires on the LIMIT-th consecutive low cycle; saturation prevents repeats.
    assign fire_o = !scl_lvl_i && (cnt_q == CW'(LIMIT - 1));
endmodule

// File: rtl/i2c_tgt_engine.sv
// Protocol state machine: address match, pointer, burst write and burst read.
module i2c_tgt_engine
    import i2c_tgt_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h48,
    parameter int         ADDR_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_rise_i,
    input  logic              scl_fall_i,
    input  logic              sda_lvl_i,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic              tmo_i,
    output logic              sda_oe_o,
    output logic              busy_o,
    output logic              wr_en_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [7:0]        wr_data_o,
    output logic              rd_en_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    input  logic [7:0]        rd_data_i
);
    tgt_state_t state_q, state_d;

    logic [BIT_CNT_W-1:0] bitcnt_q;
    logic [7:0]           rx_q;
    logic [7:0]           tx_q;
    logic [ADDR_W-1:0]    ptr_q;
    logic                 ptr_pending_q;
    logic                 rw_q;
    logic                 host_ack_q;

    logic byte_done;
    logic addr_hit;
    logic abort;

    assign byte_done = (bitcnt_q == BIT_CNT_W'(BYTE_BITS));
    assign addr_hit  = (rx_q[7:1] == DEV_ADDR);
    assign abort     = tmo_i | stop_i;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (abort) begin
            state_d = ST_IDLE;
        end else if (start_i) begin
            state_d = ST_ADDR;
        end else begin
            unique case (state_q)
                ST_IDLE:     state_d = ST_IDLE;
                ST_ADDR:     if (scl_fall_i && byte_done)
                                 state_d = addr_hit ? ST_ADDR_ACK : ST_IDLE;
                ST_ADDR_ACK: if (scl_fall_i)
                                 state_d = rw_q ? ST_RD_BYTE : ST_WR_BYTE;
                ST_WR_BYTE:  if (scl_fall_i && byte_done) state_d = ST_WR_ACK;
                ST_WR_ACK:   if (scl_fall_i) state_d = ST_WR_BYTE;
                ST_RD_BYTE:  if (scl_fall_i && byte_done) state_d = ST_RD_ACK;
                ST_RD_ACK:   if (scl_fall_i)
                                 state_d = host_ack_q ? ST_RD_BYTE : ST_IDLE;
                default:     state_d = ST_IDLE;
            endcase
        end
    end

    // Datapath and registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitcnt_q      <= '0;
            rx_q          <= '0;
            tx_q          <= '0;
            ptr_q         <= '0;
            ptr_pending_q <= 1'b0;
            rw_q          <= 1'b0;
            host_ack_q    <= 1'b0;
            sda_oe_o      <= 1'b0;
            wr_en_o       <= 1'b0;
            wr_addr_o     <= '0;
            wr_data_o     <= '0;
            rd_en_o       <= 1'b0;
        end else begin
            wr_en_o <= 1'b0;
            rd_en_o <= 1'b0;
            if (abort || start_i) begin
                sda_oe_o <= 1'b0;
                bitcnt_q <= '0;
            end else begin
                unique case (state_q)
                    ST_ADDR, ST_WR_BYTE: begin
                        if (scl_rise_i && !byte_done) begin
                            rx_q     <= {rx_q[6:0], sda_lvl_i};
                            bitcnt_q <= bitcnt_q + BIT_CNT_W'(1);
                        end
                        if (scl_fall_i && byte_done) begin
                            bitcnt_q <= '0;
                            if (state_q == ST_ADDR) begin
                                if (addr_hit) begin
                                    sda_oe_o <= 1'b1;
                                    rw_q     <= rx_q[0];
                                end
                            end else begin
                                sda_oe_o <= 1'b1;
                                if (ptr_pending_q) begin
                                    ptr_q         <= rx_q[ADDR_W-1:0];
                                    ptr_pending_q <= 1'b0;
                                end else begin
                                    wr_en_o   <= 1'b1;
                                    wr_addr_o <= ptr_q;
                                    wr_data_o <= rx_q;
                                    ptr_q     <= ptr_q + ADDR_W'(1);
                                end
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (scl_fall_i) begin
                            if (rw_q) begin
                                tx_q     <= rd_data_i;
                                sda_oe_o <= ~rd_data_i[7];
                                rd_en_o  <= 1'b1;
                                ptr_q    <= ptr_q + ADDR_W'(1);
                            end else begin
                                sda_oe_o      <= 1'b0;
                                ptr_pending_q <= 1'b1;
                            end
                        end
                    end
                    ST_WR_ACK: begin
                        if (scl_fall_i) sda_oe_o <= 1'b0;
                    end
                    ST_RD_BYTE: begin
                        if (scl_rise_i && !byte_done) bitcnt_q <= bitcnt_q + BIT_CNT_W'(1);
                        if (scl_fall_i) begin
                            if (byte_done) begin
                                sda_oe_o <= 1'b0;
                                bitcnt_q <= '0;
                            end else begin
                                tx_q     <= {tx_q[6:0], 1'b0};
                                sda_oe_o <= ~tx_q[6];
                            end
                        end
                    end
                    ST_RD_ACK: begin
                        if (scl_rise_i) host_ack_q <= ~sda_lvl_i;
                        if (scl_fall_i && host_ack_q) begin
                            tx_q     <= rd_data_i;
                            sda_oe_o <= ~rd_data_i[7];
                            rd_en_o  <= 1'b1;
                            ptr_q    <= ptr_q + ADDR_W'(1);
                        end
                    end
                    default: begin
                        sda_oe_o <= 1'b0;
                    end
                endcase
            end
        end
    end

    assign busy_o    = (state_q != ST_IDLE);
    assign rd_addr_o = ptr_q;
endmodule

// File: rtl/i2c_timeout_target.sv
module i2c_timeout_target #(
    parameter logic [6:0] DEV_ADDR    = 7'h48,
    parameter int         ADDR_W      = 8,
    parameter int         TIMEOUT_CYC = 100000,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    output logic              reg_wr_en,
    output logic [ADDR_W-1:0] reg_wr_addr,
    output logic [7:0]        reg_wr_data,
    output logic              reg_rd_en,
    output logic [ADDR_W-1:0] reg_rd_addr,
    input  logic [7:0]        reg_rd_data
);
    localparam int N_LINES = 2;   // index 0: SCL, index 1: SDA

    logic [N_LINES-1:0] pad_in;
    logic [N_LINES-1:0] lvl, rise, fall;

    assign pad_in = {sda_i, scl_i};

    for (genvar g = 0; g < N_LINES; g++) begin : g_sync
        i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk    (clk),
            .rst_n  (rst_n),
            .line_i (pad_in[g]),
            .level_o(lvl[g]),
            .rise_o (rise[g]),
            .fall_o (fall[g])
        );
    end

    logic scl_lvl, scl_rise, scl_fall, sda_lvl;
    logic start_seen, stop_seen, tmo_fire, eng_busy;

    assign scl_lvl    = lvl[0];
    assign scl_rise   = rise[0];
    assign scl_fall   = fall[0];
    assign sda_lvl    = lvl[1];
    assign start_seen = scl_lvl & ~scl_rise & fall[1];
    assign stop_seen  = scl_lvl & ~scl_rise & rise[1];

    i2c_low_watchdog #(.LIMIT(TIMEOUT_CYC)) u_wdog (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_lvl_i(scl_lvl),
        .fire_o   (tmo_fire)
    );

    i2c_tgt_engine #(.DEV_ADDR(DEV_ADDR), .ADDR_W(ADDR_W)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_rise_i(scl_rise),
        .scl_fall_i(scl_fall),
        .sda_lvl_i (sda_lvl),
        .start_i   (start_seen),
        .stop_i    (stop_seen),
        .tmo_i     (tmo_fire),
        .sda_oe_o  (sda_oe),
        .busy_o    (eng_busy),
        .wr_en_o   (reg_wr_en),
        .wr_addr_o (reg_wr_addr),
        .wr_data_o (reg_wr_data),
        .rd_en_o   (reg_rd_en),
        .rd_addr_o (reg_rd_addr),
        .rd_data_i (reg_rd_data)
    );
endmodule

// File: rtl/i2c_timeout_target_chk.sv
module i2c_timeout_target_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_lvl,
    input logic scl_fall,
    input logic start_seen,
    input logic stop_seen,
    input logic tmo_fire,
    input logic eng_busy,
    input logic sda_oe,
    input logic reg_wr_en
);
    p_start_enters_addr_r1: assert property (@(posedge clk) disable iff (!rst_n)
        start_seen |=> (eng_busy && !sda_oe));

    p_stop_goes_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        stop_seen |=> (!eng_busy && !sda_oe));

    p_drive_moves_scl_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_lvl);

    p_timeout_releases_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_fire |=> (!eng_busy && !sda_oe));

    p_timeout_scl_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_fire |-> !scl_lvl);

    p_no_commit_on_timeout_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_fire |=> !reg_wr_en);

    p_write_follows_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |-> $past(scl_fall));

    p_write_single_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |=> !reg_wr_en);

    p_idle_released_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !eng_busy |-> !sda_oe);
endmodule

bind i2c_timeout_target i2c_timeout_target_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_lvl   (scl_lvl),
    .scl_fall  (scl_fall),
    .start_seen(start_seen),
    .stop_seen (stop_seen),
    .tmo_fire  (tmo_fire),
    .eng_busy  (eng_busy),
    .sda_oe    (sda_oe),
    .reg_wr_en (reg_wr_en)
);

// File: tb/i2c_timeout_target_test.sv
module i2c_timeout_target_test;
    localparam int         AW   = 4;
    localparam int         NREG = 16;
    localparam logic [6:0] DEV  = 7'h2C;
    localparam int         TMO  = 40;
    localparam int         H    = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_h = 1'b1;
    logic sda_h = 1'b1;

    logic          sda_oe;
    logic          reg_wr_en, reg_rd_en;
    logic [AW-1:0] reg_wr_addr, reg_rd_addr;
    logic [7:0]    reg_wr_data, reg_rd_data;
    logic          sda_line;

    assign sda_line = sda_h & ~sda_oe;

    always #5 clk = ~clk;

    i2c_timeout_target #(
        .DEV_ADDR(DEV), .ADDR_W(AW), .TIMEOUT_CYC(TMO), .SYNC_STAGES(2)
    ) uut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_h), .sda_i(sda_line),
        .sda_oe(sda_oe),
        .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
        .reg_rd_en(reg_rd_en), .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data)
    );

    // Register file behind the target, plus a count of write strobes.
    logic [7:0] mem [NREG];
    int         wr_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) mem[i] <= 8'h00;
            wr_cnt <= 0;
        end else if (reg_wr_en) begin
            mem[reg_wr_addr] <= reg_wr_data;
            wr_cnt <= wr_cnt + 1;
        end
    end
    assign reg_rd_data = mem[reg_rd_addr];

    logic [7:0] exp_m [NREG];
    int exp_wr;
    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
        end
    endtask

    task automatic hw(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One data bit; the SCL low phase lasts exactly 'low' cycles.
    task automatic bit_out(input logic b, input int low);
        hw(2); sda_h = b; hw(low - 2); scl_h = 1'b1; hw(H); scl_h = 1'b0;
    endtask

    task automatic bus_start();
        sda_h = 1'b1; hw(H); scl_h = 1'b1; hw(H); sda_h = 1'b0; hw(H); scl_h = 1'b0;
    endtask

    task automatic bus_stop();
        hw(2); sda_h = 1'b0; hw(H); scl_h = 1'b1; hw(H); sda_h = 1'b1; hw(H);
    endtask

    task automatic ack_clk(output logic acked);
        hw(2); sda_h = 1'b1; hw(H); scl_h = 1'b1; hw(H/2);
        acked = ~sda_line; hw(H/2); scl_h = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) bit_out(b[i], H + 2);
        ack_clk(acked);
    endtask

    task automatic recv_byte(output logic [7:0] b, input logic give_ack);
        b = 8'h00;
        hw(2); sda_h = 1'b1;
        for (int i = 0; i < 8; i++) begin
            hw(H); scl_h = 1'b1; hw(H/2);
            b = {b[6:0], sda_line};
            hw(H/2); scl_h = 1'b0;
        end
        hw(2); sda_h = ~give_ack; hw(H); scl_h = 1'b1; hw(H); scl_h = 1'b0;
        hw(2); sda_h = 1'b1;
    endtask

    task automatic set_ptr(input int p);
        logic a;
        bus_start();
        send_byte({DEV, 1'b0}, a); chk("R2 address ack", a, 1);
        send_byte(8'(p), a);       chk("R3 pointer ack", a, 1);
    endtask

    task automatic write_burst(input int p, input int n, input int seed);
        logic a;
        logic [7:0] v;
        set_ptr(p);
        for (int k = 0; k < n; k++) begin
            v = 8'((seed * 13 + k * 29 + 3) & 8'hFF);
            send_byte(v, a); chk("R3 data ack", a, 1);
            exp_m[(p + k) % NREG] = v;
            exp_wr++;
        end
        bus_stop();
    endtask

    task automatic read_burst(input int p, input int n);
        logic a;
        logic [7:0] b;
        set_ptr(p);
        bus_start();
        send_byte({DEV, 1'b1}, a); chk("R2 read address ack", a, 1);
        for (int k = 0; k < n; k++) begin
            recv_byte(b, k != n - 1);
            chk("R4 read data", b, exp_m[(p + k) % NREG]);
        end
        bus_stop();
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic a;
        logic [7:0] b;
        for (int i = 0; i < NREG; i++) exp_m[i] = 8'h00;
        exp_wr = 0;

        // R11: reset state
        hw(3);
        chk("R11 oe in reset", sda_oe, 0);
        rst_n = 1'b1;
        hw(4);
        chk("R11 oe after reset", sda_oe, 0);
        chk("R11 wr strobe after reset", reg_wr_en, 0);
        chk("R11 rd strobe after reset", reg_rd_en, 0);

        // R3 / R4: bursts from every pointer value, crossing the wrap
        for (int p = 0; p < NREG; p++) begin
            write_burst(p, 3, p);
            read_burst(p, 3);
        end
        read_burst(9, NREG);
        chk("R10 write strobe count", wr_cnt, exp_wr);

        // R2: every foreign address is ignored
        for (int ad = 0; ad < 128; ad++) begin
            if (7'(ad) != DEV) begin
                bus_start();
                send_byte({7'(ad), 1'b0}, a);
                chk("R2 foreign address nack", a, 0);
                bus_stop();
            end
        end
        bus_start();
        send_byte({DEV ^ 7'h01, 1'b0}, a); chk("R2 mismatch nack", a, 0);
        send_byte(8'h03, a);               chk("R2 ignored byte nack", a, 0);
        send_byte(8'hEE, a);               chk("R2 ignored data nack", a, 0);
        bus_stop();
        chk("R2 no write after mismatch", wr_cnt, exp_wr);

        // R5 / R4: NACK ends the read, pointer continues afterwards
        set_ptr(7);
        bus_start();
        send_byte({DEV, 1'b1}, a); chk("R5 read address ack", a, 1);
        recv_byte(b, 1'b1); chk("R4 first byte", b, exp_m[7]);
        recv_byte(b, 1'b0); chk("R4 second byte", b, exp_m[8]);
        recv_byte(b, 1'b0); chk("R5 released after nack", b, 8'hFF);
        bus_stop();
        bus_start();
        send_byte({DEV, 1'b1}, a); chk("R4 continue address ack", a, 1);
        recv_byte(b, 1'b0); chk("R4 pointer continues", b, exp_m[9]);
        bus_stop();

        // R1: START in the middle of a byte restarts address reception
        set_ptr(5);
        bit_out(1'b1, H + 2); bit_out(1'b0, H + 2); bit_out(1'b1, H + 2);
        bus_start();
        send_byte({DEV, 1'b0}, a); chk("R1 address after restart", a, 1);
        send_byte(8'h06, a);       chk("R1 pointer after restart", a, 1);
        send_byte(8'h77, a);       chk("R1 data after restart", a, 1);
        exp_m[6] = 8'h77; exp_wr++;
        bus_stop();
        chk("R1 one write only", wr_cnt, exp_wr);
        read_burst(5, 2);

        // R9 / R6 / R7 / R8: watchdog boundary within write bytes
        set_ptr(2);
        for (int i = 7; i >= 0; i--) bit_out(8'h6E >> i, (i == 3) ? TMO - 1 : H + 2);
        ack_clk(a); chk("R9 ack after long low phase", a, 1);
        exp_m[2] = 8'h6E; exp_wr++;
        for (int i = 7; i >= 0; i--) bit_out(8'h91 >> i, (i == 3) ? TMO : H + 2);
        ack_clk(a); chk("R8 no ack after timeout", a, 0);
        chk("R6 released after timeout", sda_oe, 0);
        send_byte(8'h11, a); chk("R8 ignored until start", a, 0);
        bus_stop();
        chk("R7 partial byte not written", wr_cnt, exp_wr);
        read_burst(2, 2);

        // R6: timeout while the target drives a read bit low
        write_burst(12, 1, 0);
        exp_m[12] = 8'h03;
        bus_start();
        send_byte({DEV, 1'b0}, a); send_byte(8'd12, a); send_byte(8'h00, a);
        chk("R3 write zero ack", a, 1);
        exp_m[12] = 8'h00; exp_wr++;
        bus_start();
        send_byte({DEV, 1'b0}, a); send_byte(8'd12, a);
        bus_start();
        send_byte({DEV, 1'b1}, a); chk("R6 read address ack", a, 1);
        for (int i = 0; i < 3; i++) begin
            hw(H); scl_h = 1'b1; hw(H); scl_h = 1'b0;
        end
        hw(5);
        chk("R6 driving before timeout", sda_oe, 1);
        hw(TMO + 10);
        chk("R6 released by timeout", sda_oe, 0);
        bus_stop();
        read_burst(12, 1);
        chk("R10 final write count", wr_cnt, exp_wr);

        finish_run();
    end
endmodule